// File: doc/BRIEF.md
# Configurable Valid-Ready Register Stage

This block is one register stage on a valid/ready data path. An upstream producer offers a word with `up_vld`, and the stage takes it in any cycle where `up_rdy` is also high. The stage then offers the word downstream with `down_vld`, and the word leaves in any cycle where `down_rdy` is also high. Words leave in the order they arrived. None is dropped and none is repeated.

The `MODE` parameter picks one of five implementations. They differ in peak throughput, in area, and in whether `up_rdy` depends combinationally on `down_rdy`:

- **Mode 1:** a single pass-through register that sustains one word per cycle.
- **Mode 2:** a single register that runs at half rate, with no path from `down_rdy` to `up_rdy`.
- **Mode 3:** a single register for pipelines that stall everywhere at once.
- **Mode 4:** a two-entry FIFO whose ready comes from a register.
- **Mode 5:** a main register backed by one skid register.

An integrator chooses the mode for each stage according to the timing and area budget around it.

Top module: `hsx_stage`

## Requirements
- R1: In every mode, the sequence of words leaving the stage equals the sequence accepted, with no loss or duplication. `down_vld` is high exactly when at least one accepted word has not yet left.
- R2: When `down_vld` is high and `down_rdy` is low, the next cycle still has `down_vld` high and an unchanged `down_data`.
- R3: In mode 1, `up_rdy` equals NOT `down_vld` OR `down_rdy`. With `up_vld` and `down_rdy` held high, the stage accepts one word per cycle.
- R4: In mode 2, `up_rdy` is high only when the stage holds no word. A cycle that accepts a word is followed by a cycle with `up_rdy` low, so 20 cycles of constant offer and drain accept 10 words.
- R5: In mode 3, `up_rdy` equals `down_rdy`. While `down_rdy` is low, `down_vld` and `down_data` hold. After a cycle with `down_rdy` high, `down_vld` equals the `up_vld` of that cycle.
- R6: In mode 4, `up_rdy` is low only when two words are held. The stage sustains one word per cycle and absorbs two words while `down_rdy` is low.
- R7: In mode 5, `up_rdy` is low only when the skid register is occupied. The stage sustains one word per cycle and absorbs two words while `down_rdy` is low.
- R8: While `rst_n` is low and right after it is released, `down_vld` is low. `up_rdy` is high in modes 1, 2, 4 and 5, and equals `down_rdy` in mode 3.
- R9: A word accepted into an empty stage appears on `down_data` with `down_vld` high in the next cycle.
- R10: A `MODE` outside 1 to 5 or a `WIDTH` below 1 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_vld | input | 1 | Upstream word offered |
| up_rdy | output | 1 | Stage can take a word this cycle |
| up_data | input | WIDTH | Upstream word |
| down_vld | output | 1 | Stage offers a word downstream |
| down_rdy | input | 1 | Downstream takes the offered word |
| down_data | output | WIDTH | Word offered downstream |

## Verification
The embedded properties check the following on every cycle:

- The output holds under backpressure.
- The one-cycle latency into an empty stage.
- The idle cycle that follows each mode-2 acceptance.
- The freeze of mode 3 and its copy of the upstream valid.
- The occupancy bounds of the two-entry modes.

Only the bench's scenarios can show the rest. That covers ordered, lossless delivery across long random valid/ready patterns, the exact per-mode throughput under constant flow, and the number of words each mode absorbs under a stall. It also compares `up_rdy` against an occupancy count kept outside the design.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
   localparam int unsigned MODE_PASS  = 1;
   localparam int unsigned MODE_HALF  = 2;
   localparam int unsigned MODE_STALL = 3;
   localparam int unsigned MODE_FIFO  = 4;
   localparam int unsigned MODE_SKID  = 5;
endpackage

// File: rtl/hsx_pass_reg.sv
module hsx_pass_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   logic             full_q;
   logic [WIDTH-1:0] word_q;

   assign up_rdy    = !full_q || down_rdy;
   assign down_vld  = full_q;
   assign down_data = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (up_vld && up_rdy) begin
         full_q <= 1'b1;
      end else if (down_rdy) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (up_vld && up_rdy) word_q <= up_data;
   end

   // R9: an accepted word is presented in the following cycle
   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (up_vld && up_rdy) |=> (down_vld && down_data == $past(up_data)));
endmodule

// File: rtl/hsx_half_reg.sv
module hsx_half_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   logic             full_q;
   logic [WIDTH-1:0] word_q;

   assign up_rdy    = !full_q;
   assign down_vld  = full_q;
   assign down_data = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (!full_q && up_vld) begin
         full_q <= 1'b1;
      end else if (full_q && down_rdy) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!full_q && up_vld) word_q <= up_data;
   end

   // R4: no two acceptances in consecutive cycles
   assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_vld && up_rdy) |=> !up_rdy);
endmodule

// File: rtl/hsx_stall_reg.sv
module hsx_stall_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   logic             vld_q;
   logic [WIDTH-1:0] word_q;

   assign up_rdy    = down_rdy;
   assign down_vld  = vld_q;
   assign down_data = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (down_rdy) begin
         vld_q <= up_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (down_rdy && up_vld) word_q <= up_data;
   end

   // R5: frozen while the global ready is low
   assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !down_rdy |=> ($stable(down_vld) && $stable(down_data)));
   // R5: valid follows the upstream valid of an advancing cycle
   assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      down_rdy |=> (down_vld == $past(up_vld)));
endmodule

// File: rtl/hsx_fifo2.sv
module hsx_fifo2 #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   localparam int unsigned DEPTH = 2;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic             wr_q, rd_q;
   logic [CW-1:0]    cnt_q;
   logic             push, pop;

   assign up_rdy    = (cnt_q != CW'(DEPTH));
   assign down_vld  = (cnt_q != '0);
   assign down_data = slot_q[rd_q];
   assign push      = up_vld && up_rdy;
   assign pop       = down_vld && down_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         rd_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= !wr_q;
         if (pop)  rd_q <= !rd_q;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_q] <= up_data;
   end

   // R6: occupancy never exceeds two
   assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   // R6: refusing input implies a word is on offer
   assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !up_rdy |-> down_vld);
endmodule

// File: rtl/hsx_skid2.sv
module hsx_skid2 #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   logic             main_vld_q, skid_vld_q;
   logic [WIDTH-1:0] main_q, skid_q;
   logic             push, pop;

   assign up_rdy    = !skid_vld_q;
   assign down_vld  = main_vld_q;
   assign down_data = main_q;
   assign push      = up_vld && up_rdy;
   assign pop       = main_vld_q && down_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_vld_q <= 1'b0;
         skid_vld_q <= 1'b0;
      end else if (pop) begin
         if (skid_vld_q)  skid_vld_q <= 1'b0;
         else if (!push) main_vld_q <= 1'b0;
      end else if (push) begin
         if (main_vld_q) skid_vld_q <= 1'b1;
         else            main_vld_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (pop) begin
         if (skid_vld_q) main_q <= skid_q;
         else if (push)  main_q <= up_data;
      end else if (push) begin
         if (main_vld_q) skid_q <= up_data;
         else            main_q <= up_data;
      end
   end

   // R7: the skid register is only used behind a held main register
   assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      skid_vld_q |-> main_vld_q);
   // R7: input arriving under backpressure lands in the skid register
   assert_catch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && main_vld_q && !down_rdy) |=> !up_rdy);
endmodule

// File: rtl/hsx_stage.sv
module hsx_stage
   import hsx_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned MODE  = MODE_SKID
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_vld,
   output logic             up_rdy,
   input  logic [WIDTH-1:0] up_data,
   output logic             down_vld,
   input  logic             down_rdy,
   output logic [WIDTH-1:0] down_data
);
   // R10: reject unsupported configurations at elaboration
   if (MODE < MODE_PASS || MODE > MODE_SKID) begin : g_bad_mode
      $error("hsx_stage: MODE %0d unsupported", MODE);
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hsx_stage: WIDTH must be at least 1");
   end

   if (MODE == MODE_PASS) begin : g_pass
      hsx_pass_reg #(.WIDTH(WIDTH)) u_core (.clk, .rst_n, .up_vld, .up_rdy,
         .up_data, .down_vld, .down_rdy, .down_data);
   end else if (MODE == MODE_HALF) begin : g_half
      hsx_half_reg #(.WIDTH(WIDTH)) u_core (.clk, .rst_n, .up_vld, .up_rdy,
         .up_data, .down_vld, .down_rdy, .down_data);
   end else if (MODE == MODE_STALL) begin : g_stall
      hsx_stall_reg #(.WIDTH(WIDTH)) u_core (.clk, .rst_n, .up_vld, .up_rdy,
         .up_data, .down_vld, .down_rdy, .down_data);
   end else if (MODE == MODE_FIFO) begin : g_fifo
      hsx_fifo2 #(.WIDTH(WIDTH)) u_core (.clk, .rst_n, .up_vld, .up_rdy,
         .up_data, .down_vld, .down_rdy, .down_data);
   end else begin : g_skid
      hsx_skid2 #(.WIDTH(WIDTH)) u_core (.clk, .rst_n, .up_vld, .up_rdy,
         .up_data, .down_vld, .down_rdy, .down_data);
   end

   // R2: an offered word that is not taken stays put
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (down_vld && !down_rdy) |=> (down_vld && $stable(down_data)));
   // R8: nothing is offered in the cycle after reset
   assert_reset_R8: assert property (@(posedge clk)
      !rst_n |=> !down_vld);
endmodule

// File: tb/hsx_stage_test.sv
module hsx_stage_test;
   localparam int W  = 8;
   localparam int NM = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = !clk;

   logic         up_vld   [NM];
   logic         up_rdy   [NM];
   logic [W-1:0] up_data  [NM];
   logic         down_vld [NM];
   logic         down_rdy [NM];
   logic [W-1:0] down_data[NM];

   for (genvar m = 0; m < NM; m++) begin : g_mode
      hsx_stage #(.WIDTH(W), .MODE(m + 1)) uut (
         .clk(clk), .rst_n(rst_n),
         .up_vld(up_vld[m]), .up_rdy(up_rdy[m]), .up_data(up_data[m]),
         .down_vld(down_vld[m]), .down_rdy(down_rdy[m]), .down_data(down_data[m]));
   end

   int errs = 0, checks = 0;
   int sent[NM], rcvd[NM], acc[NM];
   logic hold_q[NM];
   logic [W-1:0] hold_d[NM];
   bit done = 0;

   function automatic logic [W-1:0] item(int m, int k);
      return W'(k * 29 + m * 7 + 3);
   endfunction

   function automatic logic exp_rdy(int m, int occ, logic dv, logic dr);
      case (m)
         0: return !dv || dr;
         1: return occ == 0;
         2: return dr;
         default: return occ < 2;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int m, int act, int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s mode %0d: actual %0d expected %0d", req, m + 1, act, exp);
      end
   endtask

   task automatic step(int pv, int pr);
      @(negedge clk);
      for (int m = 0; m < NM; m++) begin
         up_vld[m]   = ($urandom % 100) < pv;
         up_data[m]  = item(m, sent[m]);
         down_rdy[m] = ($urandom % 100) < pr;
      end
      #1;
      for (int m = 0; m < NM; m++) begin
         int occ = sent[m] - rcvd[m];
         string rq = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : (m == 3) ? "R6" : "R7";
         logic e = exp_rdy(m, occ, down_vld[m], down_rdy[m]);
         chk(up_rdy[m] == e, rq, m, up_rdy[m], e);
         chk(down_vld[m] == (occ != 0), "R1", m, down_vld[m], occ != 0);
         if (down_vld[m] && occ != 0)
            chk(down_data[m] == item(m, rcvd[m]), "R1", m, down_data[m], item(m, rcvd[m]));
         if (hold_q[m])
            chk(down_vld[m] && down_data[m] == hold_d[m], "R2", m, down_data[m], hold_d[m]);
         if (up_vld[m] && up_rdy[m]) begin sent[m]++; acc[m]++; end
         if (down_vld[m] && down_rdy[m]) rcvd[m]++;
         hold_q[m] = down_vld[m] && !down_rdy[m];
         hold_d[m] = down_data[m];
      end
   endtask

   task automatic clear_acc();
      for (int m = 0; m < NM; m++) acc[m] = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int thr_exp[NM] = '{20, 10, 20, 20, 20};
      int bp_exp[NM]  = '{1, 1, 0, 2, 2};
      void'($urandom(32'h5EED));
      for (int m = 0; m < NM; m++) begin
         up_vld[m] = 0; up_data[m] = '0; down_rdy[m] = 1;
         sent[m] = 0; rcvd[m] = 0; acc[m] = 0; hold_q[m] = 0; hold_d[m] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      // R8: state during reset
      for (int m = 0; m < NM; m++) begin
         chk(!down_vld[m], "R8", m, down_vld[m], 0);
         chk(up_rdy[m] == 1'b1, "R8", m, up_rdy[m], 1);
      end
      @(negedge clk); rst_n = 1'b1;

      // R9: single word into empty stages, visible one cycle later
      step(100, 0);
      step(0, 0);
      for (int m = 0; m < NM; m++)
         if (m != 2) chk(down_vld[m] && down_data[m] == item(m, 0), "R9", m, down_data[m], item(m, 0));
      repeat (4) step(0, 100);

      // R3 R4 R5 R6 R7: constant offer and drain throughput
      clear_acc();
      repeat (20) step(100, 100);
      for (int m = 0; m < NM; m++) chk(acc[m] == thr_exp[m], "R3 R4 R5 R6 R7 throughput", m, acc[m], thr_exp[m]);
      repeat (4) step(0, 100);

      // R5 R6 R7: words absorbed under a full stall
      clear_acc();
      repeat (6) step(100, 0);
      for (int m = 0; m < NM; m++) chk(acc[m] == bp_exp[m], "R5 R6 R7 stall", m, acc[m], bp_exp[m]);
      repeat (5) step(0, 100);
      for (int m = 0; m < NM; m++) chk(sent[m] == rcvd[m], "R1 drained", m, rcvd[m], sent[m]);

      // R1 R2: random valid/ready patterns
      for (int ph = 0; ph < 6; ph++) begin
         int pv = 30 + ph * 12, pr = 90 - ph * 12;
         repeat (800) step(pv, pr);
      end
      repeat (6) step(0, 100);
      for (int m = 0; m < NM; m++) chk(sent[m] == rcvd[m] && sent[m] > 100, "R1 random", m, rcvd[m], sent[m]);

      // R8: reset in the middle of traffic empties every mode
      repeat (3) step(100, 0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      for (int m = 0; m < NM; m++) begin
         up_vld[m] = 0; down_rdy[m] = 0; rcvd[m] = sent[m]; hold_q[m] = 0;
      end
      #1;
      for (int m = 0; m < NM; m++) begin
         chk(!down_vld[m], "R8 after reset", m, down_vld[m], 0);
         chk(up_rdy[m] == (m == 2 ? 1'b0 : 1'b1), "R8 after reset", m, up_rdy[m], m == 2 ? 0 : 1);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule